// File: doc/BRIEF.md
# Funnel Word Extractor

This block pulls a 32-bit word out of a 64-bit source, starting at any bit offset from 0 to 31. The offset is taken from a register operand or from an immediate field, as a select input chooses. Two source modes are supported. In narrow mode the 64-bit source is built from an even/odd register pair, which the block reads by driving two register-file read addresses. In wide mode the 64-bit source arrives directly as an operand.

A request is a one-cycle pulse on `req_vld`. The read addresses are derived combinationally in that same cycle. The register file returns its data one cycle later, and the extracted result with its valid flag appears in that following cycle. Wide-mode requests have the same one-cycle latency, so the two modes can be issued back to back without reordering.

Top module: `word_funnel_xtr`

## Requirements
- R1: `rf_addr_lo` equals `{src_spec[4:1], 1'b0}` in the same cycle as the request.
- R2: `rf_addr_hi` equals `{src_spec[4:1], 1'b1}` in the same cycle as the request.
- R3: `res_vld` is high exactly in the cycle after a cycle with `req_vld` high, and low otherwise.
- R4: In narrow mode (`wide_mode`=0) the source is `{rf_rdata_hi, rf_rdata_lo}`, with the odd register in bits 63:32. `res[31:0]` is source bits `pos+31` down to `pos`, and `res[63:32]` is zero.
- R5: In wide mode (`wide_mode`=1) the source is `opnd`. `res[31:0]` is `opnd` bits `pos+31` down to `pos`, and `res[63:32]` copies bit 31 of the extracted word (sign extension).
- R6: With `use_imm`=0 the offset is `pos_opnd[4:0]`. Bits 63:5 of `pos_opnd` have no effect on the result.
- R7: With `use_imm`=1 the offset is `pos_imm`, and `pos_opnd` has no effect on the result.
- R8: `res` is all zeros whenever `res_vld` is low.
- R9: Offsets 0 and 31 are handled exactly. Offset 0 returns the low register unchanged, and offset 31 takes bit 31 of the low register followed by bits 30:0 of the high register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Request strobe, one cycle per extraction |
| wide_mode | input | 1 | 1: single 64-bit operand with sign extension; 0: register pair |
| use_imm | input | 1 | 1: offset from `pos_imm`; 0: offset from `pos_opnd` |
| src_spec | input | 5 | Source register specifier (narrow mode) |
| opnd | input | 64 | 64-bit source operand (wide mode) |
| pos_opnd | input | 64 | Register operand carrying the offset in its low 5 bits |
| pos_imm | input | 5 | Immediate offset |
| rf_addr_lo | output | 5 | Read address of the even register |
| rf_addr_hi | output | 5 | Read address of the odd register |
| rf_rdata_lo | input | 32 | Even register data, one cycle after its address |
| rf_rdata_hi | input | 32 | Odd register data, one cycle after its address |
| res | output | 64 | Extracted word, zero- or sign-extended |
| res_vld | output | 1 | Result valid |

## Verification
Every offset from 0 to 31 is run in narrow mode on distinct register pairs. The reference is a plain 64-bit right shift, so any error in a shift stage or in pair order shows up at the offsets that cross the word boundary. Wide mode is run with extracted words of both signs, which separates sign extension from zero fill. Immediate and register offsets are run with the unused source loaded with conflicting values, and the upper bits of the register operand are set to show that only the low five bits count. Idle cycles after each request confirm the one-cycle valid pulse and the zeroed result.

// File: rtl/word_funnel_xtr.sv
module word_funnel_xtr #(
  parameter int WORD_W = 32,
  parameter int SPEC_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_vld,
  input  logic                wide_mode,
  input  logic                use_imm,
  input  logic [SPEC_W-1:0]   src_spec,
  input  logic [2*WORD_W-1:0] opnd,
  input  logic [2*WORD_W-1:0] pos_opnd,
  input  logic [$clog2(WORD_W)-1:0] pos_imm,
  output logic [SPEC_W-1:0]   rf_addr_lo,
  output logic [SPEC_W-1:0]   rf_addr_hi,
  input  logic [WORD_W-1:0]   rf_rdata_lo,
  input  logic [WORD_W-1:0]   rf_rdata_hi,
  output logic [2*WORD_W-1:0] res,
  output logic                res_vld
);
  localparam int SRC_W = 2 * WORD_W;
  localparam int POS_W = $clog2(WORD_W);

  logic             vld_q, wide_q;
  logic [POS_W-1:0] pos_q;
  logic [SRC_W-1:0] opnd_q;
  logic [SRC_W-1:0] stg [POS_W+1];
  logic [WORD_W-1:0] word;

  assign rf_addr_lo = {src_spec[SPEC_W-1:1], 1'b0};
  assign rf_addr_hi = {src_spec[SPEC_W-1:1], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      wide_q <= 1'b0;
      pos_q  <= '0;
      opnd_q <= '0;
    end else begin
      vld_q <= req_vld;
      if (req_vld) begin
        wide_q <= wide_mode;
        pos_q  <= use_imm ? pos_imm : pos_opnd[POS_W-1:0];
        opnd_q <= opnd;
      end
    end
  end

  assign stg[0] = wide_q ? opnd_q : {rf_rdata_hi, rf_rdata_lo};

  for (genvar k = 0; k < POS_W; k++) begin : g_shift
    assign stg[k+1] = pos_q[k] ? (stg[k] >> (1 << k)) : stg[k];
  end

  assign word    = stg[POS_W][WORD_W-1:0];
  assign res_vld = vld_q;
  assign res     = !vld_q ? '0 :
                   wide_q ? {{WORD_W{word[WORD_W-1]}}, word} :
                            {{WORD_W{1'b0}}, word};

  AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> res_vld) else $error("valid missing after request"); // R3
  AST_NO_STRAY_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !res_vld) else $error("valid without request"); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> (res == '0)) else $error("result not zero when idle"); // R8
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !wide_q) |-> (res[SRC_W-1:WORD_W] == '0)) else $error("narrow upper half"); // R4
  AST_WIDE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && wide_q) |-> (res[SRC_W-1:WORD_W] == {WORD_W{res[WORD_W-1]}})) else $error("wide sign"); // R5
  AST_ZERO_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !wide_q && pos_q == '0) |-> (res[WORD_W-1:0] == rf_rdata_lo)) else $error("offset zero"); // R9
endmodule

// File: tb/test_word_funnel_xtr.sv
`timescale 1ns/1ps
module test_word_funnel_xtr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_vld = 1'b0, wide_mode = 1'b0, use_imm = 1'b0;
  logic [4:0] src_spec = '0, pos_imm = '0;
  logic [63:0] opnd = '0, pos_opnd = '0;
  logic [4:0] rf_addr_lo, rf_addr_hi;
  logic [31:0] rf_rdata_lo, rf_rdata_hi;
  logic [63:0] res;
  logic res_vld;
  logic [31:0] rf [32];
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  word_funnel_xtr i_word_funnel_xtr (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .wide_mode(wide_mode),
    .use_imm(use_imm), .src_spec(src_spec), .opnd(opnd), .pos_opnd(pos_opnd),
    .pos_imm(pos_imm), .rf_addr_lo(rf_addr_lo), .rf_addr_hi(rf_addr_hi),
    .rf_rdata_lo(rf_rdata_lo), .rf_rdata_hi(rf_rdata_hi), .res(res), .res_vld(res_vld));

  always_ff @(posedge clk) begin
    rf_rdata_lo <= rf[rf_addr_lo];
    rf_rdata_hi <= rf[rf_addr_hi];
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(logic wide, logic [63:0] src, int p);
    logic [63:0] s = src >> p;
    return wide ? {{32{s[31]}}, s[31:0]} : {32'h0, s[31:0]};
  endfunction

  task automatic run(string req, logic wide, logic imm, logic [4:0] spec,
                     logic [63:0] op, logic [63:0] pr, logic [4:0] pi, int p);
    logic [63:0] src;
    @(negedge clk);
    req_vld = 1'b1; wide_mode = wide; use_imm = imm; src_spec = spec;
    opnd = op; pos_opnd = pr; pos_imm = pi;
    #1;
    chk("R1 lo addr", {59'h0, rf_addr_lo}, {59'h0, spec[4:1], 1'b0});
    chk("R2 hi addr", {59'h0, rf_addr_hi}, {59'h0, spec[4:1], 1'b1});
    src = wide ? op : {rf[{spec[4:1], 1'b1}], rf[{spec[4:1], 1'b0}]};
    @(negedge clk);
    req_vld = 1'b0; opnd = ~op; pos_opnd = ~pr; pos_imm = ~pi;
    chk("R3 valid", {63'h0, res_vld}, 64'h1);
    chk(req, res, model(wide, src, p));
    @(negedge clk);
    chk("R3 valid drop", {63'h0, res_vld}, 64'h0);
    chk("R8 idle zero", res, 64'h0);
  endtask

  task automatic t_reset;
    #1;
    chk("R3 reset valid", {63'h0, res_vld}, 64'h0);
    chk("R8 reset result", res, 64'h0);
  endtask

  task automatic t_sweep_narrow;
    for (int p = 0; p < 32; p++)
      run("R4 narrow sweep", 1'b0, 1'b0, 5'(p), 64'hDEAD_0000_BEEF_0000, 64'(p), 5'(31 - p), p);
  endtask

  task automatic t_edges;
    run("R9 offset zero", 1'b0, 1'b0, 5'd6, '0, 64'd0, 5'd17, 0);
    run("R9 offset max", 1'b0, 1'b0, 5'd7, '0, 64'd31, 5'd0, 31);
  endtask

  task automatic t_wide;
    run("R5 wide negative", 1'b1, 1'b0, 5'd3, 64'h0123_4567_89AB_CDEF, 64'd0, 5'd9, 0);
    run("R5 wide positive", 1'b1, 1'b0, 5'd3, 64'h0123_4567_89AB_CDEF, 64'd4, 5'd9, 4);
    run("R5 wide cross", 1'b1, 1'b0, 5'd3, 64'hF0F0_1234_8765_4321, 64'd20, 5'd1, 20);
  endtask

  task automatic t_regpos_upper;
    run("R6 upper pos bits", 1'b0, 1'b0, 5'd10, '0, 64'hFFFF_FFFF_FFFF_FFE5, 5'd2, 5);
    run("R6 upper pos bits wide", 1'b1, 1'b0, 5'd0, 64'h8000_0001_7FFF_FFFE, 64'hA5A5_0000_0000_0060, 5'd31, 0);
  endtask

  task automatic t_imm;
    run("R7 immediate", 1'b0, 1'b1, 5'd21, '0, 64'd3, 5'd13, 13);
    run("R7 immediate wide", 1'b1, 1'b1, 5'd0, 64'h7654_3210_FEDC_BA98, 64'd31, 5'd16, 16);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = (32'h9E37_79B9 * (i + 1)) ^ (32'h0F0F_3355 << (i % 7));
    t_reset;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_sweep_narrow;
    t_edges;
    t_wide;
    t_regpos_upper;
    t_imm;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule